// File: doc/BRIEF.md
# CRC32C Accumulate, Store and Check Unit

This unit rides next to a DMA data path and folds a CRC32C checksum over the data stream, one beat per clock. Each job is opened with a one-cycle `job_go` pulse that carries its settings. Data beats follow on `in_valid`/`in_data`, and `in_last` marks the final beat. The running CRC can be carried from one job to the next, so a checksum can span several buffers. A job can also restart the register from a seed that it supplies.

When a job closes, the unit does one of three things. By default it only accumulates, and nothing is written. In store mode it writes the final checksum, either as an extra beat appended to the output stream or as a strobe on a separate result port. In test mode it compares the checksum with an expected value. That value is either the trailing beat of the input stream or the `exp_crc` input. The unit can run as copy-with-CRC, where input beats pass through to the output stream, or as CRC-only, where no data is forwarded.

Top module: `crc32c_unit`

## Requirements
- R1: After reset all outputs are low and the CRC register holds 0xFFFFFFFF. A first job without a seed therefore starts a fresh checksum: eight zero beats yield 0x8A9136AA.
- R2: The checksum is CRC32C. It uses the reflected polynomial 0x82F63B78, and each beat is folded least significant byte first, least significant bit first. The reported value is the register XOR 0xFFFFFFFF. Eight 0xFFFFFFFF beats from a fresh start yield 0x62A8AB43. Bytes 0x00 to 0x1F, packed little-endian into beats, yield 0x46DD794E.
- R3: A job with neither store nor test writes nothing. No `res_wr` is raised and no CRC beat is appended. The register keeps its value for the next job.
- R4: When `job_seed_ok` is high with `job_go`, the register is loaded with `job_seed` XOR 0xFFFFFFFF. Seeding with 0 restarts the checksum, and seeding with a prior result continues it. Without the flag, the job continues from the register.
- R5: In store mode without the inline flag, `res_wr` pulses with `job_done` and `res_crc` carries the final checksum.
- R6: In store mode with the inline flag, one extra output beat holding the checksum follows the data, in the same cycle as `job_done`. Only that extra beat has `out_last` set. In CRC-only mode this beat is the only output.
- R7: With `job_copy` set, each accepted data beat appears on the output stream one cycle after it is accepted, in the same order. With `job_copy` clear, no data beat is forwarded.
- R8: In test mode without the inline flag, `exp_crc` is sampled together with the last beat. `crc_mismatch` pulses with `job_done` when `exp_crc` differs from the checksum.
- R9: In test mode with the inline flag, the last input beat is the expected checksum. That beat is neither folded into the CRC nor forwarded, and `crc_mismatch` reports whether it differs from the checksum.
- R10: When store and test are both requested, `job_err` pulses with `job_done`. No result is written, no beat is appended or withheld, and no mismatch is raised. The data is still folded and, with `job_copy`, forwarded.
- R11: `job_done` is a one-cycle pulse two cycles after the last beat is accepted. With it, `res_crc` shows the job's checksum in every mode, and `res_crc` holds that value until the next `job_done`.
- R12: `job_go` and the job settings are ignored while a job is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_go | input | 1 | Opens a job; settings below are sampled with it |
| job_seed_ok | input | 1 | Load the register from `job_seed` |
| job_seed | input | 32 | Seed value (a checksum value) |
| job_store | input | 1 | Emit the checksum at job end |
| job_test | input | 1 | Compare the checksum at job end |
| job_inline | input | 1 | Use the data stream for the stored/expected checksum |
| job_copy | input | 1 | Forward data beats to the output stream |
| exp_crc | input | 32 | Expected checksum, sampled with the last beat |
| in_valid | input | 1 | Input beat valid |
| in_data | input | DATA_W | Input beat |
| in_last | input | 1 | Last beat of the job |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output beat (forwarded data or checksum) |
| out_last | output | 1 | Last output beat of the job |
| job_done | output | 1 | Job completion pulse |
| job_err | output | 1 | Store and test both requested |
| crc_mismatch | output | 1 | Test failed |
| res_wr | output | 1 | Checksum write strobe on the result port |
| res_crc | output | 32 | Checksum of the latest completed job |

## Verification
The checker watches the completion signalling on every cycle. It confirms that `job_done` is a single pulse and that error, mismatch and result-write strobes only occur with it and never together. It also confirms that an output beat coinciding with completion is a final CRC beat, and that `res_crc` moves only at completion. The checksum values themselves only show up in the bench's scenarios. These scenarios cover the known vectors, chaining across jobs with and without seeds, withholding of the inline expected beat, the conflicting-mode error, and a `job_go` pulse that is ignored while a job is active.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

  localparam int unsigned CRC_W = 32;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BODY = 2'd1,
    PH_WRAP = 2'd2
  } phase_t;

  typedef struct packed {
    logic store;
    logic test;
    logic inl;
    logic copy;
  } job_cfg_t;

endpackage

// File: rtl/crc32c_core.sv
module crc32c_core #(
  parameter int unsigned DATA_W = 32,
  parameter logic [31:0] POLY   = 32'h82F63B78,
  parameter logic [31:0] INIT   = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [31:0]       load_val,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data,
  output logic [31:0]       crc_q
);

  logic [31:0] crc_d;

  // bit-serial reflected fold, lowest data bit first
  function automatic logic [31:0] fold(input logic [31:0] c, input logic [DATA_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < DATA_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (load_en)     crc_d = load_val;
    else if (upd_en) crc_d = fold(crc_q, upd_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc_q <= INIT;
    else if (load_en | upd_en) crc_q <= crc_d;
  end

endmodule

// File: rtl/crc32c_ctrl.sv
module crc32c_ctrl
  import crc32c_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_go,
  input  job_cfg_t          cfg_in,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic [31:0]       exp_crc,
  output logic              accept,
  output logic              feed,
  output logic              fwd,
  output logic              fwd_last,
  output logic              wrap,
  output logic              store_ok,
  output logic              test_ok,
  output logic              conflict,
  output logic              inl,
  output logic [31:0]       exp_q
);

  phase_t      phase_q, phase_d;
  job_cfg_t    cfg_q;
  logic [31:0] exp_d;
  logic        beat, withhold, exp_en;

  assign accept   = job_go && (phase_q == PH_IDLE);
  assign wrap     = (phase_q == PH_WRAP);
  assign conflict = cfg_q.store & cfg_q.test;
  assign store_ok = cfg_q.store & ~cfg_q.test;
  assign test_ok  = cfg_q.test & ~cfg_q.store;
  assign inl      = cfg_q.inl;

  always_comb begin
    beat     = in_valid && (phase_q == PH_BODY);
    withhold = beat & in_last & test_ok & cfg_q.inl;
    feed     = beat & ~withhold;
    fwd      = beat & cfg_q.copy & ~withhold;
    fwd_last = in_last & ~(store_ok & cfg_q.inl);
    exp_en   = beat & in_last;
    exp_d    = withhold ? in_data[31:0] : exp_crc;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (job_go) phase_d = PH_BODY;
      PH_BODY: if (beat && in_last) phase_d = PH_WRAP;
      PH_WRAP: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_q <= '0;
    else if (exp_en) exp_q <= exp_d;
  end

endmodule

// File: rtl/crc32c_emit.sv
module crc32c_emit #(
  parameter int unsigned DATA_W = 32,
  parameter logic [31:0] XOROUT = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              fwd_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic              wrap,
  input  logic              store_ok,
  input  logic              test_ok,
  input  logic              conflict,
  input  logic              inl,
  input  logic [31:0]       crc_q,
  input  logic [31:0]       exp_q,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              job_done,
  output logic              job_err,
  output logic              crc_mismatch,
  output logic              res_wr,
  output logic [31:0]       res_crc
);

  logic [31:0]       final_crc;
  logic              ov_d, ol_d, done_d, err_d, mm_d, wr_d, od_en;
  logic [DATA_W-1:0] od_d;

  assign final_crc = crc_q ^ XOROUT;

  always_comb begin
    ov_d  = 1'b0;
    ol_d  = 1'b0;
    od_d  = out_data;
    od_en = 1'b0;
    if (fwd) begin
      ov_d  = 1'b1;
      ol_d  = fwd_last;
      od_d  = in_data;
      od_en = 1'b1;
    end else if (wrap && store_ok && inl) begin
      ov_d  = 1'b1;
      ol_d  = 1'b1;
      od_d  = DATA_W'(final_crc);
      od_en = 1'b1;
    end
    done_d = wrap;
    err_d  = wrap & conflict;
    wr_d   = wrap & store_ok & ~inl;
    mm_d   = wrap & test_ok & (final_crc != exp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_last     <= 1'b0;
      job_done     <= 1'b0;
      job_err      <= 1'b0;
      res_wr       <= 1'b0;
      crc_mismatch <= 1'b0;
    end else begin
      out_valid    <= ov_d;
      out_last     <= ol_d;
      job_done     <= done_d;
      job_err      <= err_d;
      res_wr       <= wr_d;
      crc_mismatch <= mm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_data <= '0;
    else if (od_en) out_data <= od_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_crc <= '0;
    else if (wrap) res_crc <= final_crc;
  end

endmodule

// File: rtl/crc32c_unit.sv
module crc32c_unit
  import crc32c_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [31:0] POLY   = 32'h82F63B78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_go,
  input  logic              job_seed_ok,
  input  logic [31:0]       job_seed,
  input  logic              job_store,
  input  logic              job_test,
  input  logic              job_inline,
  input  logic              job_copy,
  input  logic [31:0]       exp_crc,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              job_done,
  output logic              job_err,
  output logic              crc_mismatch,
  output logic              res_wr,
  output logic [31:0]       res_crc
);

  localparam logic [CRC_W-1:0] ALL_ONES = '1;

  job_cfg_t    cfg_in;
  logic        accept, feed, fwd, fwd_last, wrap;
  logic        store_ok, test_ok, conflict, inl;
  logic [31:0] exp_q, crc_q;

  assign cfg_in = '{store: job_store, test: job_test, inl: job_inline, copy: job_copy};

  crc32c_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .job_go   (job_go),
    .cfg_in   (cfg_in),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_data  (in_data),
    .exp_crc  (exp_crc),
    .accept   (accept),
    .feed     (feed),
    .fwd      (fwd),
    .fwd_last (fwd_last),
    .wrap     (wrap),
    .store_ok (store_ok),
    .test_ok  (test_ok),
    .conflict (conflict),
    .inl      (inl),
    .exp_q    (exp_q)
  );

  crc32c_core #(.DATA_W(DATA_W), .POLY(POLY), .INIT(ALL_ONES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (accept & job_seed_ok),
    .load_val (job_seed ^ ALL_ONES),
    .upd_en   (feed),
    .upd_data (in_data),
    .crc_q    (crc_q)
  );

  crc32c_emit #(.DATA_W(DATA_W), .XOROUT(ALL_ONES)) u_emit (
    .clk          (clk),
    .rst_n        (rst_n),
    .fwd          (fwd),
    .fwd_last     (fwd_last),
    .in_data      (in_data),
    .wrap         (wrap),
    .store_ok     (store_ok),
    .test_ok      (test_ok),
    .conflict     (conflict),
    .inl          (inl),
    .crc_q        (crc_q),
    .exp_q        (exp_q),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_last     (out_last),
    .job_done     (job_done),
    .job_err      (job_err),
    .crc_mismatch (crc_mismatch),
    .res_wr       (res_wr),
    .res_crc      (res_crc)
  );

endmodule

// File: rtl/crc32c_unit_chk.sv
module crc32c_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_last,
  input logic        job_done,
  input logic        job_err,
  input logic        crc_mismatch,
  input logic        res_wr,
  input logic [31:0] res_crc
);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !job_done |-> $stable(res_crc));

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    job_err |-> (job_done && !res_wr && !crc_mismatch && !out_valid));

  assert_wr_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> (job_done && !crc_mismatch));

  assert_mismatch_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_mismatch |-> job_done);

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_done_beat_is_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (job_done && out_valid) |-> out_last);

endmodule

bind crc32c_unit crc32c_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_valid    (out_valid),
  .out_last     (out_last),
  .job_done     (job_done),
  .job_err      (job_err),
  .crc_mismatch (crc_mismatch),
  .res_wr       (res_wr),
  .res_crc      (res_crc)
);

// File: tb/crc32c_unit_bench.sv
`timescale 1ns/1ps
module crc32c_unit_bench;

  typedef struct packed { logic [31:0] d; logic l; } obeat_t;
  typedef struct packed { logic err; logic mm; logic wr; logic [31:0] crc; } odone_t;

  logic        clk, rst_n;
  logic        job_go, job_seed_ok, job_store, job_test, job_inline, job_copy;
  logic [31:0] job_seed, exp_crc, in_data, out_data, res_crc;
  logic        in_valid, in_last;
  logic        out_valid, out_last, job_done, job_err, crc_mismatch, res_wr;

  int          checks = 0, failures = 0;
  bit          finished = 0;
  logic [31:0] pl[$];
  obeat_t      exp_out[$];
  odone_t      exp_done[$];
  logic [31:0] m_crc, last_res;
  string       cur_tag = "R1";

  crc32c_unit u_crc32c_unit (
    .clk(clk), .rst_n(rst_n), .job_go(job_go), .job_seed_ok(job_seed_ok),
    .job_seed(job_seed), .job_store(job_store), .job_test(job_test),
    .job_inline(job_inline), .job_copy(job_copy), .exp_crc(exp_crc),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .job_done(job_done), .job_err(job_err), .crc_mismatch(crc_mismatch),
    .res_wr(res_wr), .res_crc(res_crc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] w);
    logic [31:0] r;
    r = c ^ w;
    for (int k = 0; k < 32; k++) r = r[0] ? ((r >> 1) ^ 32'h82F63B78) : (r >> 1);
    return r;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic fill(int n, logic [31:0] base, logic [31:0] inc);
    pl.delete();
    for (int i = 0; i < n; i++) pl.push_back(base + inc * i);
  endtask

  // expm: 1 = correct expected value, 2 = wrong expected value
  task automatic run_job(string tag, bit sd, logic [31:0] seed, bit st, bit te,
                         bit il, bit cp, int expm, bit poke, bit gaps);
    logic [31:0] c, fin, expv;
    bit err, wh, app;
    int n;
    n   = pl.size();
    err = st & te;
    wh  = te & il & !err;
    app = st & il & !err;
    c   = sd ? ~seed : m_crc;
    for (int i = 0; i < n; i++) begin
      if (!(wh && i == n - 1)) c = ref_step(c, pl[i]);
    end
    fin  = ~c;
    expv = (expm == 1) ? fin : (fin ^ 32'h0000_0100);
    if (wh) pl[n-1] = expv;
    for (int i = 0; i < n; i++) begin
      if (cp && !(wh && i == n - 1)) exp_out.push_back({pl[i], (i == n - 1) && !app});
    end
    if (app) exp_out.push_back({fin, 1'b1});
    exp_done.push_back({err, te && !err && (fin != expv), st && !il && !err, fin});
    m_crc   = c;
    cur_tag = tag;

    @(negedge clk);
    job_go = 1; job_seed_ok = sd; job_seed = seed; job_store = st; job_test = te;
    job_inline = il; job_copy = cp; exp_crc = expv;
    @(negedge clk);
    job_go = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1; in_data = pl[i]; in_last = (i == n - 1);
      if (poke && i == 1) begin
        // R12: a new job request mid-stream must change nothing
        job_go = 1; job_seed_ok = 1; job_seed = 32'hDEADBEEF;
        job_store = 1; job_test = 1; job_copy = ~cp; job_inline = ~il;
      end
      @(negedge clk);
      job_go = 0;
    end
    in_valid = 0; in_last = 0;
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        checks++;
        if (exp_out.size() == 0) begin
          failures++;
          $display("FAIL R7 %s unexpected beat actual=%h expected=none", cur_tag, out_data);
        end else begin
          obeat_t e;
          e = exp_out.pop_front();
          if (out_data !== e.d || out_last !== e.l) begin
            failures++;
            $display("FAIL R7/R6 %s beat actual=%h/%b expected=%h/%b",
                     cur_tag, out_data, out_last, e.d, e.l);
          end
        end
      end
      if (job_done) begin
        checks++;
        last_res = res_crc;
        if (exp_done.size() == 0) begin
          failures++;
          $display("FAIL R11 %s unexpected done actual=1 expected=0", cur_tag);
        end else begin
          odone_t e;
          e = exp_done.pop_front();
          if (res_crc !== e.crc || job_err !== e.err || crc_mismatch !== e.mm || res_wr !== e.wr) begin
            failures++;
            $display("FAIL R2/R5/R8/R10 %s done actual=%h err%b mm%b wr%b expected=%h err%b mm%b wr%b",
                     cur_tag, res_crc, job_err, crc_mismatch, res_wr, e.crc, e.err, e.mm, e.wr);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; job_go = 0; job_seed_ok = 0; job_seed = 0; job_store = 0; job_test = 0;
    job_inline = 0; job_copy = 0; exp_crc = 0; in_valid = 0; in_data = 0; in_last = 0;
    m_crc = 32'hFFFFFFFF; last_res = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check32("R1 outputs after reset",
            {out_valid, out_last, job_done, job_err, crc_mismatch, res_wr}, 32'd0);
    check32("R1 res_crc after reset", res_crc, 32'd0);

    // R1/R2: fresh start from reset value, accumulate only, CRC-only
    fill(8, 32'h0, 32'h0);
    run_job("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check32("R1 zero vector", last_res, 32'h8A9136AA);

    // R2/R4/R5: seed 0 restarts; separate store
    fill(8, 32'hFFFFFFFF, 32'h0);
    run_job("R5", 1, 32'h0, 1, 0, 0, 0, 0, 0, 0);
    check32("R2 ones vector", last_res, 32'h62A8AB43);

    // R2/R6/R7: ascending bytes, copy with inline store
    fill(8, 32'h03020100, 32'h04040404);
    run_job("R6", 1, 32'h0, 1, 0, 1, 1, 0, 0, 0);
    check32("R2 ascending vector", last_res, 32'h46DD794E);

    // R3: accumulate over two jobs, then result is chained
    fill(4, 32'h11223344, 32'h01010101);
    run_job("R3", 1, 32'h0, 0, 0, 0, 1, 0, 0, 0);
    fill(4, 32'hA5A5F00F, 32'h10203040);
    run_job("R3", 0, 0, 1, 0, 0, 0, 0, 0, 1);

    // R4: seed with the previous result continues the checksum
    fill(3, 32'h0BADF00D, 32'h13579BDF);
    run_job("R4", 1, last_res, 1, 0, 0, 1, 0, 0, 0);

    // R8: separate test, pass then fail
    fill(5, 32'hCAFE0000, 32'h00000777);
    run_job("R8", 1, 32'h0, 0, 1, 0, 0, 1, 0, 0);
    fill(5, 32'hCAFE0000, 32'h00000777);
    run_job("R8", 1, 32'h0, 0, 1, 0, 1, 2, 0, 1);

    // R9: inline test, copy pass and CRC-only fail
    fill(6, 32'h12345678, 32'h11111111);
    run_job("R9", 1, 32'h0, 0, 1, 1, 1, 1, 0, 0);
    fill(6, 32'h87654321, 32'h22222222);
    run_job("R9", 1, 32'h0, 0, 1, 1, 0, 2, 0, 0);

    // R6: inline store, CRC-only emits a lone checksum beat
    fill(4, 32'h55AA55AA, 32'h00FF00FF);
    run_job("R6", 0, 0, 1, 0, 1, 0, 0, 0, 1);

    // R10: conflicting modes, inline flag set, copy on
    fill(4, 32'hF0F0F0F0, 32'h01020304);
    run_job("R10", 1, 32'h0, 1, 1, 1, 1, 1, 0, 0);

    // R12: go pulse during a running job is ignored
    fill(5, 32'h31415926, 32'h27182818);
    run_job("R12", 0, 0, 1, 0, 0, 1, 0, 1, 0);

    // R11: nothing left unobserved
    check32("R11 leftover beats", exp_out.size(), 0);
    check32("R11 leftover completions", exp_done.size(), 0);
    summary();
  end

endmodule